// File: doc/BRIEF.md
# Pulse-Width Tape Frame Transmitter

This block turns a range of memory bytes into one framed record on a single-bit tape line. Every bit is a symmetric pulse: the line is driven high for N ticks and then low for N ticks, with a long N for a one and a short N for a zero. A tick is a fixed number of clocks set by a parameter.

A frame is made of four parts, sent in this order:

- a preamble of repeated sync bytes, each followed by a run of single zero pulses;
- a record-marker byte;
- the data bytes, read from a synchronous memory port with one cycle of latency;
- a 16-bit additive checksum of the data bytes.

A host starts a frame by giving a start address and an end address and pulsing `start`. It then waits for the one-cycle `done` pulse.

Bytes are fetched ahead of use through a one-entry holding register. Because of this, pulses follow each other with no idle clocks anywhere in the frame.

Top module: `tape_frame_tx`

## Requirements
- R1: Each bit drives `tape_out` high for N ticks and then low for N ticks. N is ONE_TICKS (default 0x50) for a one and ZERO_TICKS (default 0x20) for a zero. One tick is TICK_DIV clocks.
- R2: A byte is sent as one start pulse with value one, then its 8 data bits most-significant first. No stop bit follows.
- R3: The frame opens with SYNC_COUNT (default 32) copies of the sync byte SYNC_CODE (default 0x16). Each copy is followed by GAP_PULSES (default 16) single zero pulses that carry no start bit.
- R4: Right after the preamble the marker byte MARK_CODE (default 0x0F) is sent once.
- R5: The checksum is cleared after the marker. Each data byte is added to it as an unsigned 8-bit value, with the carry from the low byte going into the high byte.
- R6: The frame ends with the checksum low byte and then the checksum high byte, each sent as a normal byte.
- R7: Data bytes are sent from memory address `start_addr` upward, one address per byte, and stop once the next address is greater than or equal to `end_addr`. The byte at `end_addr` is never sent. If `start_addr >= end_addr`, no data byte is sent and the checksum is 0x0000. `mem_rdata` is taken one clock after `mem_rd`.
- R8: Out of reset, and between frames, `tape_out` is low and `busy` is low. `done` is high for exactly one clock after the low half of the last pulse has ended.
- R9: A `start` pulse while `busy` is high has no effect on the frame in progress.
- R10: Inside a frame, each pulse begins on the clock at which the low half of the previous pulse ends, so no idle time appears between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to send a frame |
| start_addr | input | ADDR_W | First data address, sampled with `start` |
| end_addr | input | ADDR_W | Address one past the last data byte, sampled with `start` |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_rd` |
| tape_out | output | 1 | Serial tape line |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
The bench decodes the tape line back into pulses and bytes, and compares the result with a frame model built from the requirements.

A fault in the tick or pulse counters shows up within one pulse. It appears as a high or low half whose length is neither the long nor the short width.

A fault in the bit or byte sequencing shows up in the first byte affected. Examples are a lost start bit, a reversed bit order, or a wrong count of gap zeros; each moves every later bit of the preamble.

A fault in the address walk or the checksum reaches the line only late in the frame, in the data or trailer segment. A stall in refilling the holding register shows as a low half that is longer than its high half.

// File: rtl/tape_tx_pkg.sv
// Package: types shared by the tape frame transmitter.
// Assumes nothing beyond IEEE 1800-2017.
package tape_tx_pkg;

    // Phase of the frame walk.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_GAP,
        PH_MARK,
        PH_DATA,
        PH_CKLO,
        PH_CKHI,
        PH_DRAIN
    } frame_phase_t;

    // One unit handed to the serializer: a full byte with start bit,
    // or a single zero pulse.
    typedef struct packed {
        logic       is_byte;
        logic [7:0] value;
    } tape_item_t;

endpackage

// File: rtl/tick_divider.sv
// Module: tick_divider
// Produces a one-clock tick every DIV clocks.
// A synchronous clear restarts the count, so the first tick comes DIV
// clocks after the clear. Assumes DIV >= 2.
module tick_divider #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count clocks; wrap at the end of a tick period or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                       // R1
endmodule

// File: rtl/pulse_writer.sv
// Module: pulse_writer
// Sends one bit at a time as a high half and then a low half, each of
// len ticks. A new bit is taken on the clock at which the previous low
// half ends, so back-to-back bits have no gap. The tick counter is
// restarted on every take.
module pulse_writer #(
    parameter int ONE_TICKS  = 8'h50,
    parameter int ZERO_TICKS = 8'h20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bit_valid,
    input  logic bit_value,
    output logic bit_take,
    output logic tick_clr,
    output logic busy,
    output logic tape_out
);
    localparam int MAXT = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
    localparam int LW   = $clog2(MAXT + 1);
    localparam logic [LW-1:0] ONE_L  = LW'(ONE_TICKS);
    localparam logic [LW-1:0] ZERO_L = LW'(ZERO_TICKS);

    logic          busy_q, high_q;
    logic [LW-1:0] len_q, tcnt_q;
    logic          last_tick, fin;

    assign last_tick = busy_q && tick && (tcnt_q == len_q - 1'b1);
    assign fin       = last_tick && !high_q;
    assign bit_take  = bit_valid && (!busy_q || fin);
    assign tick_clr  = bit_take;
    assign busy      = busy_q;
    assign tape_out  = busy_q && high_q;

    // Run the high/low halves of the current pulse and accept the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            high_q <= 1'b0;
            len_q  <= ZERO_L;
            tcnt_q <= '0;
        end else if (bit_take) begin
            busy_q <= 1'b1;
            high_q <= 1'b1;
            len_q  <= bit_value ? ONE_L : ZERO_L;
            tcnt_q <= '0;
        end else if (last_tick) begin
            tcnt_q <= '0;
            if (high_q) high_q <= 1'b0;
            else        busy_q <= 1'b0;
        end else if (busy_q && tick) begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    AST_TCNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (tcnt_q < len_q));                         // R1
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (len_q == ONE_L || len_q == ZERO_L));      // R1
    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        bit_take |=> tape_out);                               // R1
endmodule

// File: rtl/symbol_serializer.sv
// Module: symbol_serializer
// Turns items into a bit stream. A byte item becomes a one-valued start
// bit followed by 8 data bits, most-significant first. A zero item is a
// single zero bit. The next item is loaded on the clock at which the
// last bit of the current one is taken.
module symbol_serializer
    import tape_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       item_valid,
    input  tape_item_t item,
    output logic       item_take,
    output logic       bit_valid,
    output logic       bit_value,
    input  logic       bit_take,
    output logic       active
);
    logic       act_q;
    logic [8:0] sreg_q;
    logic [3:0] left_q;
    logic       load_now;

    assign load_now  = item_valid && (!act_q || (bit_take && left_q == 4'd1));
    assign item_take = load_now;
    assign bit_valid = act_q;
    assign bit_value = sreg_q[8];
    assign active    = act_q;

    // Load items and shift out one bit per take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            sreg_q <= '0;
            left_q <= '0;
        end else if (load_now) begin
            act_q  <= 1'b1;
            sreg_q <= item.is_byte ? {1'b1, item.value} : 9'd0;
            left_q <= item.is_byte ? 4'd9 : 4'd1;
        end else if (bit_take) begin
            sreg_q <= {sreg_q[7:0], 1'b0};
            left_q <= left_q - 1'b1;
            if (left_q == 4'd1) act_q <= 1'b0;
        end
    end

    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (left_q >= 4'd1 && left_q <= 4'd9));        // R2
    AST_START_BIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && item.is_byte) |=> bit_value);            // R2
    AST_TAKE_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_take |-> act_q);                                  // R10
endmodule

// File: rtl/frame_sequencer.sv
// Module: frame_sequencer
// Walks the frame: preamble, marker, data, then the checksum.
// It keeps a one-entry holding register that the serializer drains;
// the holding register is refilled as soon as it empties, so the next
// item is ready long before it is needed. Data come from a read port
// with one clock of latency.
module frame_sequencer
    import tape_tx_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter logic [7:0] SYNC_CODE  = 8'h16,
    parameter logic [7:0] MARK_CODE  = 8'h0F,
    parameter int         SYNC_COUNT = 32,
    parameter int         GAP_PULSES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              item_valid,
    output tape_item_t        item,
    input  logic              item_take,
    input  logic              ser_active,
    input  logic              pw_busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done
);
    localparam int RW = $clog2(SYNC_COUNT + 1);
    localparam int GW = $clog2(GAP_PULSES + 1);
    localparam logic [RW-1:0] REP_LAST = RW'(SYNC_COUNT - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_PULSES - 1);

    frame_phase_t      state_q;
    tape_item_t        hold_q;
    logic              hold_v;
    logic [RW-1:0]     rep_q;
    logic [GW-1:0]     gap_q;
    logic [ADDR_W-1:0] addr_q, end_q, addr_next;
    logic [15:0]       cks_q;
    logic              rd_pend, done_q;

    assign addr_next  = addr_q + 1'b1;
    assign item_valid = hold_v;
    assign item       = hold_q;
    assign mem_rd     = (state_q == PH_DATA) && !hold_v && !rd_pend;
    assign mem_addr   = addr_q;
    assign busy       = (state_q != PH_IDLE);
    assign done       = done_q;

    // Frame walk, holding-register refill, address walk and checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            hold_q  <= '0;
            hold_v  <= 1'b0;
            rep_q   <= '0;
            gap_q   <= '0;
            addr_q  <= '0;
            end_q   <= '0;
            cks_q   <= '0;
            rd_pend <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (item_take) hold_v <= 1'b0;
            unique case (state_q)
                PH_IDLE: begin
                    if (start) begin
                        addr_q  <= start_addr;
                        end_q   <= end_addr;
                        rep_q   <= '0;
                        gap_q   <= '0;
                        state_q <= PH_SYNC;
                    end
                end
                PH_SYNC: begin
                    if (!hold_v) begin
                        hold_q  <= '{is_byte: 1'b1, value: SYNC_CODE};
                        hold_v  <= 1'b1;
                        gap_q   <= '0;
                        state_q <= PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (!hold_v) begin
                        hold_q <= '{is_byte: 1'b0, value: 8'h00};
                        hold_v <= 1'b1;
                        if (gap_q == GAP_LAST) begin
                            gap_q <= '0;
                            if (rep_q == REP_LAST) begin
                                state_q <= PH_MARK;
                            end else begin
                                rep_q   <= rep_q + 1'b1;
                                state_q <= PH_SYNC;
                            end
                        end else begin
                            gap_q <= gap_q + 1'b1;
                        end
                    end
                end
                PH_MARK: begin
                    if (!hold_v) begin
                        hold_q  <= '{is_byte: 1'b1, value: MARK_CODE};
                        hold_v  <= 1'b1;
                        cks_q   <= '0;
                        state_q <= (addr_q >= end_q) ? PH_CKLO : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (rd_pend) begin
                        hold_q  <= '{is_byte: 1'b1, value: mem_rdata};
                        hold_v  <= 1'b1;
                        cks_q   <= cks_q + {8'h00, mem_rdata};
                        addr_q  <= addr_next;
                        rd_pend <= 1'b0;
                        if (addr_next >= end_q) state_q <= PH_CKLO;
                    end else if (!hold_v) begin
                        rd_pend <= 1'b1;
                    end
                end
                PH_CKLO: begin
                    if (!hold_v) begin
                        hold_q  <= '{is_byte: 1'b1, value: cks_q[7:0]};
                        hold_v  <= 1'b1;
                        state_q <= PH_CKHI;
                    end
                end
                PH_CKHI: begin
                    if (!hold_v) begin
                        hold_q  <= '{is_byte: 1'b1, value: cks_q[15:8]};
                        hold_v  <= 1'b1;
                        state_q <= PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    if (!hold_v && !ser_active && !pw_busy) begin
                        done_q  <= 1'b1;
                        state_q <= PH_IDLE;
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    AST_ADDR_BELOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DATA) |-> (addr_q < end_q));           // R7
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && !item_take) |=> (hold_v && $stable(hold_q))); // R10
    AST_RANGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE) |=> ($stable(end_q)));           // R9
    AST_CKS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_MARK && !hold_v) |=> (cks_q == 16'h0000)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);                                  // R8
    AST_READ_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> rd_pend);                                  // R7
endmodule

// File: rtl/tape_frame_tx.sv
// Module: tape_frame_tx (top)
// Pulse-width tape frame transmitter. The frame sequencer feeds items
// to the serializer, which feeds bits to the pulse writer. The pulse
// writer is timed by the tick divider. Assumes TICK_DIV >= 2, pulse
// lengths >= 1 tick, SYNC_COUNT >= 1 and GAP_PULSES >= 1.
module tape_frame_tx
    import tape_tx_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter int         TICK_DIV   = 8,
    parameter int         ONE_TICKS  = 8'h50,
    parameter int         ZERO_TICKS = 8'h20,
    parameter int         SYNC_COUNT = 32,
    parameter int         GAP_PULSES = 16,
    parameter logic [7:0] SYNC_CODE  = 8'h16,
    parameter logic [7:0] MARK_CODE  = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              tape_out,
    output logic              busy,
    output logic              done
);
    tape_item_t item;
    logic item_valid, item_take, ser_active;
    logic bit_valid, bit_value, bit_take;
    logic tick, tick_clr, pw_busy;

    frame_sequencer #(
        .ADDR_W(ADDR_W), .SYNC_CODE(SYNC_CODE), .MARK_CODE(MARK_CODE),
        .SYNC_COUNT(SYNC_COUNT), .GAP_PULSES(GAP_PULSES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_addr(start_addr), .end_addr(end_addr),
        .item_valid(item_valid), .item(item), .item_take(item_take),
        .ser_active(ser_active), .pw_busy(pw_busy),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done)
    );

    symbol_serializer u_ser (
        .clk(clk), .rst_n(rst_n),
        .item_valid(item_valid), .item(item), .item_take(item_take),
        .bit_valid(bit_valid), .bit_value(bit_value), .bit_take(bit_take),
        .active(ser_active)
    );

    tick_divider #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
    );

    pulse_writer #(.ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS)) u_pw (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bit_valid(bit_valid), .bit_value(bit_value), .bit_take(bit_take),
        .tick_clr(tick_clr), .busy(pw_busy), .tape_out(tape_out)
    );

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tape_out);                                 // R8
    AST_NO_BITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pw_busy);                                  // R8
endmodule

// File: tb/sim_tape_frame_tx.sv
// Directed bench for tape_frame_tx. The bench decodes tape_out into
// pulses and compares them with a frame model built from the requirements.
module sim_tape_frame_tx;
    localparam int TDIV = 2;
    localparam int ONE_T = 5;
    localparam int ZERO_T = 2;
    localparam int REPS = 4;
    localparam int GAPS = 3;
    localparam int ONE_CLK = ONE_T * TDIV;
    localparam int ZERO_CLK = ZERO_T * TDIV;
    localparam int MAXP = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] start_addr = '0, end_addr = '0;
    logic mem_rd;
    logic [15:0] mem_addr;
    logic [7:0] mem_rdata = '0;
    logic tape_out, busy, done;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tape_frame_tx #(
        .TICK_DIV(TDIV), .ONE_TICKS(ONE_T), .ZERO_TICKS(ZERO_T),
        .SYNC_COUNT(REPS), .GAP_PULSES(GAPS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_addr(start_addr), .end_addr(end_addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .tape_out(tape_out), .busy(busy), .done(done)
    );

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return 8'(a[7:0] * 8'd37 + 8'd200);
    endfunction

    // Memory with one cycle of read latency.
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_fn(mem_addr);

    // Pulse monitor.
    int ph[MAXP];
    int pl[MAXP];
    int np = 0;
    logic prev = 1'b0;
    int run = 0;
    int hi_len = 0;
    bit have_hi = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev = 1'b0; run = 0; have_hi = 0;
        end else begin
            if (tape_out !== prev) begin
                if (prev) begin
                    hi_len = run; have_hi = 1;
                end else if (have_hi) begin
                    if (np < MAXP) begin ph[np] = hi_len; pl[np] = run; end
                    np++; have_hi = 0;
                end
                prev = tape_out; run = 1;
            end else begin
                run++;
            end
            if (done && have_hi && !tape_out) begin
                if (np < MAXP) begin ph[np] = hi_len; pl[np] = run; end
                np++; have_hi = 0;
            end
        end
    end

    // Expected bit stream.
    bit exp_b[MAXP];
    int exp_n = 0;

    task automatic add_bit(input bit b);
        if (exp_n < MAXP) exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic add_byte(input logic [7:0] v);
        add_bit(1'b1);
        for (int i = 7; i >= 0; i--) add_bit(v[i]);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Count mismatches between decoded bits and expected bits in [lo, hi).
    function automatic int seg_miss(input int lo, input int hi);
        int m = 0;
        for (int i = lo; i < hi; i++) begin
            bit got;
            if (i >= np || i >= MAXP) begin m++; continue; end
            got = (ph[i] == ONE_CLK);
            if (got != exp_b[i]) m++;
        end
        return m;
    endfunction

    task automatic pulse_start(input logic [15:0] sa, input logic [15:0] ea);
        @(negedge clk);
        start_addr = sa; end_addr = ea; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Send one frame and check every segment; optionally fire a
    // conflicting start while the frame is in progress.
    task automatic run_frame(input logic [15:0] sa, input logic [15:0] ea,
                             input bit poke, input string name);
        int nbytes, shape_bad, gap_bad, waitc, pre_end, mark_end, data_end;
        logic [15:0] cks;
        np = 0; exp_n = 0; cks = 16'h0; nbytes = 0;
        for (int r = 0; r < REPS; r++) begin
            add_byte(8'h16);
            for (int g = 0; g < GAPS; g++) add_bit(1'b0);
        end
        add_byte(8'h0F);
        for (logic [16:0] a = {1'b0, sa}; a < {1'b0, ea}; a++) begin
            add_byte(mem_fn(a[15:0]));
            cks = cks + {8'h00, mem_fn(a[15:0])};
            nbytes++;
        end
        add_byte(cks[7:0]);
        add_byte(cks[15:8]);
        pre_end = REPS * (9 + GAPS);
        mark_end = pre_end + 9;
        data_end = mark_end + 9 * nbytes;

        pulse_start(sa, ea);
        if (poke) begin
            repeat (150) @(negedge clk);
            check(busy === 1'b1, {name, " R9 busy before poke"}, busy, 1);
            pulse_start(sa + 16'h0040, ea + 16'h0080);
        end
        waitc = 0;
        while (done !== 1'b1 && waitc < 60000) begin
            @(negedge clk); waitc++;
        end
        check(done === 1'b1, {name, " R8 done seen"}, done, 1);
        @(negedge clk);
        check(done === 1'b0, {name, " R8 done one cycle"}, done, 0);
        check(busy === 1'b0 && tape_out === 1'b0, {name, " R8 idle low after frame"},
              {busy, tape_out}, 0);

        shape_bad = 0; gap_bad = 0;
        for (int i = 0; i < np && i < MAXP; i++) begin
            if (ph[i] != ONE_CLK && ph[i] != ZERO_CLK) shape_bad++;
            if (i < np - 1 && pl[i] != ph[i]) gap_bad++;
            if (i == np - 1 && pl[i] < ph[i]) shape_bad++;
        end
        check(shape_bad == 0, {name, " R1 pulse widths"}, shape_bad, 0);
        check(gap_bad == 0, {name, " R10 symmetric halves no gaps"}, gap_bad, 0);
        check(np == exp_n, {name, " R2 total pulse count"}, np, exp_n);
        check(seg_miss(0, pre_end) == 0, {name, " R3 preamble"}, seg_miss(0, pre_end), 0);
        check(seg_miss(pre_end, mark_end) == 0, {name, " R4 marker"},
              seg_miss(pre_end, mark_end), 0);
        check(seg_miss(mark_end, data_end) == 0, {name, " R7 R2 data bytes"},
              seg_miss(mark_end, data_end), 0);
        check(seg_miss(data_end, data_end + 9) == 0, {name, " R5 R6 checksum low"},
              seg_miss(data_end, data_end + 9), 0);
        check(seg_miss(data_end + 9, data_end + 18) == 0, {name, " R5 R6 checksum high"},
              seg_miss(data_end + 9, data_end + 18), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(tape_out === 1'b0, "R8 reset tape low", tape_out, 0);
        check(busy === 1'b0, "R8 reset not busy", busy, 0);
        check(done === 1'b0, "R8 reset no done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_basic();      run_frame(16'h0010, 16'h0015, 0, "basic");   endtask
    task automatic t_empty();      run_frame(16'h0020, 16'h0020, 0, "R7 empty"); endtask
    task automatic t_reversed();   run_frame(16'h0030, 16'h0028, 0, "R7 reversed"); endtask
    task automatic t_carry();      run_frame(16'h0000, 16'h000C, 0, "R5 carry");  endtask
    task automatic t_ignore();     run_frame(16'h0050, 16'h0053, 1, "R9 ignore"); endtask
    task automatic t_high_page();  run_frame(16'h12FE, 16'h1302, 0, "R7 page cross"); endtask

    initial begin
        t_reset();
        t_basic();
        t_empty();
        t_reversed();
        t_carry();
        t_ignore();
        t_high_page();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule